// File: doc/BRIEF.md
# SECDED-Protected RAM Slave Port

This block lets an external bus master read and write a tightly coupled on-chip RAM whose words carry single-error-correct, double-error-detect check bits. Requests are single-beat and carry a word address, 32 data bits, four byte strobes, a privilege flag and a write/read flag. Each request gets exactly one response with a two-bit code and, for reads, the data. The RAM itself sits outside the block. It has a one-cycle read latency and reports an error indication in the cycle after each enabled access.

On writes the port computes the check bits and stores them next to the data. A write that covers only part of the 32-bit word becomes an internal read, merge and write. Reads are decoded. A single flipped bit is corrected in the returned data, but the RAM copy is left as it is. A double error gives an error response. Four static control inputs set the behaviour: permission gating (block everything, or block unprivileged requests), error checking on or off, and whether RAM-side errors are reported. Late-error and retry hints from the RAM are ignored.

The controller is a single state machine:
- `ST_IDLE` accepts a request. From there it goes to `ST_RESP` when the request is refused, to `ST_RD` for a read, to `ST_WR` for a full-word write, and to `ST_MRD` for a partial write.
- A read runs `ST_RD` → `ST_RWAIT` → `ST_RESP`.
- A partial write runs `ST_MRD` → `ST_MWAIT`. It then goes to `ST_WR`, or to `ST_RESP` when the write is aborted.
- A write of the word runs `ST_WR` → `ST_WACK` → `ST_RESP`.
- `ST_RESP` → `ST_IDLE`.

Top module: `ecc_mem_port`

## Requirements
- R1: A write stores a 39-bit word. Bits [31:0] hold the data. Bits [37:32] hold six Hamming check bits: the data bits are placed in ascending order at codeword positions 1..38 that are not powers of two, and check bit k is the XOR of the data at positions whose index has bit k set. Bit 38 makes the XOR of all 39 bits zero.
- R2: A write with all four strobes set makes one RAM write and no RAM read. A write with strobes 4'b0001..4'b1110 makes one RAM read, then one RAM write of the old word with the strobed bytes replaced (strobe bit b selects data bits [8b+7:8b]).
- R3: With checking on, a read of a word with one flipped bit (data or check bit) returns the original data with response 2'b00 (OKAY).
- R4: A read never writes the RAM, so a corrected word stays corrupted in storage.
- R5: With checking on, a read of a word with two flipped bits returns response 2'b10 (SLVERR).
- R6: With checking off, a read returns the stored data bits unchanged with OKAY, whatever the check bits say.
- R7: When the RAM raises its error indication, the response is SLVERR if the external-error enable is set and OKAY (normal data) if it is clear.
- R8: The RAM's late-error and retry hints have no effect on the response code or data.
- R9: With block-all set, every request is refused. With block-unprivileged set, requests with privilege 0 are refused. A refused request gets SLVERR one cycle after acceptance and makes no RAM access.
- R10: If the read phase of a partial write finds an uncorrectable error (checking on), or a reported RAM error, the write is dropped. The RAM is not written and the response is SLVERR.
- R11: `req_ready` is high only in idle and drops in the cycle after a request is accepted. Each accepted request yields exactly one one-cycle `rsp_valid` pulse.
- R12: During and right after reset, `req_ready` is 1 and `rsp_valid` and `ram_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_block_all | input | 1 | Refuse every request |
| ctl_block_unpriv | input | 1 | Refuse requests with privilege 0 |
| ctl_check_en | input | 1 | Enable ECC checking and correction on reads |
| ctl_exterr_en | input | 1 | Report RAM-side errors as SLVERR |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged request |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes for writes |
| rsp_valid | output | 1 | Response pulse |
| rsp_resp | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM word address |
| ram_wdata | output | 39 | Codeword to store |
| ram_rdata | input | 39 | Codeword read, valid the cycle after a read |
| ram_err | input | 1 | RAM error, valid the cycle after an access |
| ram_late_err | input | 1 | Late error hint (ignored) |
| ram_retry | input | 1 | Retry hint (ignored) |

## Verification
The assertions assume that the control inputs are stable while a request is in flight. They also assume that `ram_rdata` and `ram_err` follow the one-cycle access timing, since the decode result and error are judged in the wait states. The bench changes controls and error injection only between transactions, while the port is idle. Its RAM model registers both read data and the error flag one cycle after `ram_en`. Corruption is applied only by flipping stored bits between transactions.

// File: rtl/ecc_port_pkg.sv
package ecc_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RWAIT,
        ST_MRD,
        ST_MWAIT,
        ST_WR,
        ST_WACK,
        ST_RESP
    } port_state_t;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    // number of Hamming check bits for a given data width
    function automatic int hm_r(input int dw);
        int r;
        r = 0;
        for (int t = 0; t < 16; t++) begin
            if ((1 << r) < dw + r + 1) r++;
        end
        return r;
    endfunction

    // codeword position of data bit i (skips powers of two)
    function automatic int hm_pos(input int i);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 3; p < 512; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == i && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    function automatic int code_w(input int dw);
        return dw + hm_r(dw) + 1;
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
    import ecc_port_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]           data_i,
    output logic [code_w(DW)-1:0]   code_o
);
    localparam int R  = hm_r(DW);

    logic [R-1:0] contrib [DW];
    logic [R-1:0] hchk;
    logic         ovp;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        localparam int P = hm_pos(i);
        assign contrib[i] = {R{data_i[i]}} & P[R-1:0];
    end

    always_comb begin
        hchk = '0;
        for (int i = 0; i < DW; i++) begin
            hchk = hchk ^ contrib[i];
        end
        ovp = ^{data_i, hchk};
    end

    assign code_o = {ovp, hchk, data_i};

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_port_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [code_w(DW)-1:0]   code_i,
    output logic [DW-1:0]           data_o,
    output logic                    single_o,
    output logic                    double_o
);
    localparam int R  = hm_r(DW);
    localparam int CW = code_w(DW);

    logic [CW-1:0] recalc;
    logic [R-1:0]  syn;
    logic [DW-1:0] hit;
    logic          overall;
    logic          locatable;

    ecc_secded_enc #(.DW(DW)) u_recalc (
        .data_i (code_i[DW-1:0]),
        .code_o (recalc)
    );

    assign syn     = code_i[DW+R-1:DW] ^ recalc[DW+R-1:DW];
    assign overall = ^code_i;

    for (genvar i = 0; i < DW; i++) begin : g_fix
        localparam int P = hm_pos(i);
        assign hit[i]    = (syn == P[R-1:0]);
        assign data_o[i] = code_i[i] ^ (single_o & hit[i]);
    end

    always_comb begin
        locatable = (syn == '0) | $onehot(syn) | (|hit);
        single_o  = overall & locatable;
        double_o  = (!overall && (syn != '0)) || (overall && !locatable);
    end

endmodule

// File: rtl/ecc_port_ctrl.sv
module ecc_port_ctrl
    import ecc_port_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_block_all,
    input  logic            ctl_block_unpriv,
    input  logic            ctl_check_en,
    input  logic            ctl_exterr_en,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic            req_priv,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_strb,
    output logic            rsp_valid,
    output logic [1:0]      rsp_resp,
    output logic [DW-1:0]   rsp_rdata,
    output logic            ram_en,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   wr_data,
    input  logic [DW-1:0]   raw_data,
    input  logic [DW-1:0]   dec_data,
    input  logic            dec_single,
    input  logic            dec_double,
    input  logic            ram_err,
    input  logic            ram_late_err,
    input  logic            ram_retry
);
    localparam int NB = DW / 8;

    port_state_t   state, state_nx;
    logic          cur_write;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_data;
    logic [NB-1:0] cur_strb;
    logic          err_q;
    logic [DW-1:0] rdata_q;

    logic          deny;
    logic          rd_bad;
    logic          rmw_abort;
    logic [DW-1:0] base;
    logic [DW-1:0] merged;

    always_comb begin
        deny      = ctl_block_all | (ctl_block_unpriv & ~req_priv);
        rd_bad    = (ram_err & ctl_exterr_en) | (ctl_check_en & dec_double);
        rmw_abort = rd_bad;
        base      = ctl_check_en ? dec_data : raw_data;
        for (int b = 0; b < NB; b++) begin
            merged[8*b +: 8] = cur_strb[b] ? cur_data[8*b +: 8] : base[8*b +: 8];
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (deny)            state_nx = ST_RESP;
                    else if (!req_write) state_nx = ST_RD;
                    else if (&req_strb)  state_nx = ST_WR;
                    else                 state_nx = ST_MRD;
                end
            end
            ST_RD:    state_nx = ST_RWAIT;
            ST_RWAIT: state_nx = ST_RESP;
            ST_MRD:   state_nx = ST_MWAIT;
            ST_MWAIT: state_nx = rmw_abort ? ST_RESP : ST_WR;
            ST_WR:    state_nx = ST_WACK;
            ST_WACK:  state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_data  <= '0;
            cur_strb  <= '0;
            err_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_write <= req_write;
                        cur_addr  <= req_addr;
                        cur_data  <= req_wdata;
                        cur_strb  <= req_strb;
                        err_q     <= deny;
                        rdata_q   <= '0;
                    end
                end
                ST_RWAIT: begin
                    rdata_q <= base;
                    err_q   <= rd_bad;
                end
                ST_MWAIT: begin
                    cur_data <= merged;
                    err_q    <= rmw_abort;
                end
                ST_WACK: begin
                    err_q <= ram_err & ctl_exterr_en;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        ram_en    = (state == ST_RD) || (state == ST_MRD) || (state == ST_WR);
        ram_we    = (state == ST_WR);
        ram_addr  = cur_addr;
        wr_data   = cur_data;
        rsp_valid = (state == ST_RESP);
        rsp_resp  = err_q ? RESP_SLVERR : RESP_OKAY;
        rsp_rdata = rdata_q;
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11
    AST_RSP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11
    AST_BLOCK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ctl_block_all) |=> (rsp_valid && rsp_resp == RESP_SLVERR && !ram_en)); // R9
    AST_WE_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> cur_write); // R4
    AST_DEC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RWAIT || state == ST_MWAIT) |-> $onehot0({dec_single, dec_double})); // R3
    AST_UNCORR_SLVERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RWAIT && ctl_check_en && dec_double) |=> (rsp_valid && rsp_resp == RESP_SLVERR)); // R5
    AST_RMW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MWAIT && ctl_check_en && dec_double) |=> (!ram_en && rsp_valid && rsp_resp == RESP_SLVERR)); // R10
    AST_HINTS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RWAIT && (ram_late_err || ram_retry) && !ram_err && !(ctl_check_en && dec_double))
        |=> (rsp_resp == RESP_OKAY)); // R8

endmodule

// File: rtl/ecc_mem_port.sv
module ecc_mem_port
    import ecc_port_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_block_all,
    input  logic                  ctl_block_unpriv,
    input  logic                  ctl_check_en,
    input  logic                  ctl_exterr_en,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_priv,
    input  logic [AW-1:0]         req_addr,
    input  logic [DW-1:0]         req_wdata,
    input  logic [DW/8-1:0]       req_strb,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_resp,
    output logic [DW-1:0]         rsp_rdata,
    output logic                  ram_en,
    output logic                  ram_we,
    output logic [AW-1:0]         ram_addr,
    output logic [code_w(DW)-1:0] ram_wdata,
    input  logic [code_w(DW)-1:0] ram_rdata,
    input  logic                  ram_err,
    input  logic                  ram_late_err,
    input  logic                  ram_retry
);
    logic [DW-1:0] wr_data;
    logic [DW-1:0] dec_data;
    logic          dec_single;
    logic          dec_double;

    ecc_secded_enc #(.DW(DW)) u_enc (
        .data_i (wr_data),
        .code_o (ram_wdata)
    );

    ecc_secded_dec #(.DW(DW)) u_dec (
        .code_i   (ram_rdata),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    ecc_port_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .ctl_block_all    (ctl_block_all),
        .ctl_block_unpriv (ctl_block_unpriv),
        .ctl_check_en     (ctl_check_en),
        .ctl_exterr_en    (ctl_exterr_en),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_write        (req_write),
        .req_priv         (req_priv),
        .req_addr         (req_addr),
        .req_wdata        (req_wdata),
        .req_strb         (req_strb),
        .rsp_valid        (rsp_valid),
        .rsp_resp         (rsp_resp),
        .rsp_rdata        (rsp_rdata),
        .ram_en           (ram_en),
        .ram_we           (ram_we),
        .ram_addr         (ram_addr),
        .wr_data          (wr_data),
        .raw_data         (ram_rdata[DW-1:0]),
        .dec_data         (dec_data),
        .dec_single       (dec_single),
        .dec_double       (dec_double),
        .ram_err          (ram_err),
        .ram_late_err     (ram_late_err),
        .ram_retry        (ram_retry)
    );

endmodule

// File: tb/sim_ecc_mem_port.sv
module sim_ecc_mem_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_block_all = 0, ctl_block_unpriv = 0, ctl_check_en = 1, ctl_exterr_en = 1;
    logic        req_valid = 0, req_write = 0, req_priv = 1;
    logic [7:0]  req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic [3:0]  req_strb = 0;
    logic        req_ready, rsp_valid, ram_en, ram_we;
    logic [1:0]  rsp_resp;
    logic [31:0] rsp_rdata;
    logic [7:0]  ram_addr;
    logic [38:0] ram_wdata;
    logic [38:0] ram_rdata = '0;
    logic        ram_err = 0, ram_late_err = 0, ram_retry = 0;

    logic [38:0] mem [256];
    logic        inj_err = 0;
    int          rd_cnt, wr_cnt, pulses;
    logic [1:0]  got_resp;
    logic [31:0] got_data;
    logic        ready_after;
    int          checks = 0, failures = 0;

    always #4 clk = ~clk;

    ecc_mem_port u0 (.*);

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin mem[ram_addr] <= ram_wdata; wr_cnt++; end
            else        begin ram_rdata <= mem[ram_addr]; rd_cnt++; end
        end
        ram_err <= ram_en & inj_err;
    end

    function automatic logic [38:0] enc_ref(input logic [31:0] d);
        logic [38:1] cw;
        logic [6:0]  c;
        int j;
        cw = '0; j = 0; c = '0;
        for (int p = 1; p <= 38; p++)
            if ((p & (p - 1)) != 0) begin cw[p] = d[j]; j++; end
        for (int k = 0; k < 6; k++)
            for (int p = 1; p <= 38; p++)
                if (p[k]) c[k] = c[k] ^ cw[p];
        c[6] = ^{d, c[5:0]};
        return {c, d};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic wr, input logic pv, input logic [3:0] st,
                       input logic [7:0] ad, input logic [31:0] dt);
        logic got;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_priv = pv; req_strb = st;
        req_addr = ad; req_wdata = dt;
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        req_valid = 0;
        ready_after = req_ready;
        pulses = 0; got = 0; got_resp = 2'b11; got_data = 'x;
        for (int n = 0; n < 12; n++) begin
            if (rsp_valid) begin
                pulses++;
                if (!got) begin got_resp = rsp_resp; got_data = rsp_rdata; end
                got = 1;
            end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [3:0]  strb;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 4'hF, 8'h01, 32'hDEADBEEF, 32'h0},
        '{1'b0, 4'h0, 8'h01, 32'h0,        32'hDEADBEEF},
        '{1'b1, 4'h1, 8'h01, 32'h00000055, 32'h0},
        '{1'b0, 4'h0, 8'h01, 32'h0,        32'hDEADBE55},
        '{1'b1, 4'hC, 8'h01, 32'h12340000, 32'h0},
        '{1'b0, 4'h0, 8'h01, 32'h0,        32'h1234BE55},
        '{1'b1, 4'hF, 8'h02, 32'h00000000, 32'h0},
        '{1'b0, 4'h0, 8'h02, 32'h0,        32'h00000000},
        '{1'b1, 4'h6, 8'h02, 32'hFFABCDFF, 32'h0},
        '{1'b0, 4'h0, 8'h02, 32'h0,        32'h00ABCD00}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [38:0] saved;
        for (int a = 0; a < 256; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        check("R12 ready in reset", {63'd0, req_ready}, 64'd1);
        check("R12 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R12 ram_en after reset", {63'd0, ram_en}, 64'd0);
        check("R12 ready after reset", {63'd0, req_ready}, 64'd1);

        // table-driven write/merge/read sequence (R2, R3 path clean)
        for (int v = 0; v < 10; v++) begin
            txn(VEC[v].wr, 1'b1, VEC[v].strb, VEC[v].addr, VEC[v].data);
            check($sformatf("R2 vec%0d resp", v), {62'd0, got_resp}, 64'd0);
            if (!VEC[v].wr) check($sformatf("R2 vec%0d data", v), {32'd0, got_data}, {32'd0, VEC[v].exp});
        end

        // R1: stored codewords
        txn(1, 1, 4'hF, 8'h05, 32'hA5A50F0F);
        check("R1 codeword A5A50F0F", {25'd0, mem[5]}, {25'd0, enc_ref(32'hA5A50F0F)});
        check("R11 ready low after accept", {63'd0, ready_after}, 64'd0);
        check("R11 single response pulse", pulses, 1);
        txn(1, 1, 4'hF, 8'h06, 32'hFFFFFFFF);
        check("R1 codeword FFFFFFFF", {25'd0, mem[6]}, {25'd0, enc_ref(32'hFFFFFFFF)});
        check("R2 full write reads", rd_cnt, 0);
        check("R2 full write writes", wr_cnt, 1);
        txn(1, 1, 4'h2, 8'h06, 32'h00003C00);
        check("R2 partial write reads", rd_cnt, 1);
        check("R2 partial write writes", wr_cnt, 1);
        check("R2 partial merged word", {25'd0, mem[6]}, {25'd0, enc_ref(32'hFFFF3CFF)});

        // R3 / R4: single data bit flip corrected, not written back
        mem[5][7] = ~mem[5][7];
        saved = mem[5];
        txn(0, 1, 4'h0, 8'h05, 32'h0);
        check("R3 corrected data", {32'd0, got_data}, {32'd0, 32'hA5A50F0F});
        check("R3 corrected resp", {62'd0, got_resp}, 64'd0);
        check("R4 no write during read", wr_cnt, 0);
        check("R4 stored word still corrupt", {25'd0, mem[5]}, {25'd0, saved});
        mem[5][34] = ~mem[5][34];
        mem[5][7]  = ~mem[5][7];
        txn(0, 1, 4'h0, 8'h05, 32'h0);
        check("R3 check bit flip data", {32'd0, got_data}, {32'd0, 32'hA5A50F0F});
        check("R3 check bit flip resp", {62'd0, got_resp}, 64'd0);
        mem[5][34] = ~mem[5][34];

        // R5: double error
        mem[5][3] = ~mem[5][3]; mem[5][20] = ~mem[5][20];
        txn(0, 1, 4'h0, 8'h05, 32'h0);
        check("R5 double error resp", {62'd0, got_resp}, 64'd2);

        // R6: checking off returns raw bits
        ctl_check_en = 0;
        txn(0, 1, 4'h0, 8'h05, 32'h0);
        check("R6 raw data", {32'd0, got_data}, {32'd0, 32'hA5A50F0F ^ 32'h00100008});
        check("R6 raw resp", {62'd0, got_resp}, 64'd0);
        ctl_check_en = 1;

        // R10: partial write over double error aborts
        saved = mem[5];
        txn(1, 1, 4'h1, 8'h05, 32'h000000AA);
        check("R10 abort resp", {62'd0, got_resp}, 64'd2);
        check("R10 no RAM write", wr_cnt, 0);
        check("R10 memory unchanged", {25'd0, mem[5]}, {25'd0, saved});

        // R7: RAM-side error
        inj_err = 1;
        txn(0, 1, 4'h0, 8'h01, 32'h0);
        check("R7 ram error enabled", {62'd0, got_resp}, 64'd2);
        ctl_exterr_en = 0;
        txn(0, 1, 4'h0, 8'h01, 32'h0);
        check("R7 ram error disabled resp", {62'd0, got_resp}, 64'd0);
        check("R7 ram error disabled data", {32'd0, got_data}, {32'd0, 32'h1234BE55});
        ctl_exterr_en = 1;
        txn(1, 1, 4'hF, 8'h07, 32'h11111111);
        check("R7 write with ram error", {62'd0, got_resp}, 64'd2);
        inj_err = 0;

        // R8: hints ignored
        ram_late_err = 1; ram_retry = 1;
        txn(0, 1, 4'h0, 8'h01, 32'h0);
        check("R8 hints resp", {62'd0, got_resp}, 64'd0);
        check("R8 hints data", {32'd0, got_data}, {32'd0, 32'h1234BE55});
        ram_late_err = 0; ram_retry = 0;

        // R9: permission gating
        ctl_block_all = 1;
        txn(0, 1, 4'h0, 8'h01, 32'h0);
        check("R9 block all resp", {62'd0, got_resp}, 64'd2);
        check("R9 block all no access", rd_cnt + wr_cnt, 0);
        ctl_block_all = 0; ctl_block_unpriv = 1;
        txn(1, 0, 4'hF, 8'h01, 32'h0BADF00D);
        check("R9 unpriv refused", {62'd0, got_resp}, 64'd2);
        check("R9 unpriv no access", rd_cnt + wr_cnt, 0);
        txn(0, 1, 4'h0, 8'h01, 32'h0);
        check("R9 priv allowed resp", {62'd0, got_resp}, 64'd0);
        check("R9 priv allowed data", {32'd0, got_data}, {32'd0, 32'h1234BE55});
        check("R11 pulse on read", pulses, 1);
        ctl_block_unpriv = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule